// File: doc/BRIEF.md
# Configuration Access Router

This block takes a single configuration request and steers it to one target function among several buses. The 24-bit request address is split into three fields: a bus number, a device/function number and a register offset. Bus number 0 is always the root bus. Each bridge on the root bus owns one secondary bus. A bridge's bus number register is loaded by ordinary configuration writes to that bridge, and this register decides which secondary bus answers a request.

Downstream, every function has its own select line. All functions share the offset, length, write flag and write data lines. During the request cycle the selected function drives its read data. The router returns a registered response one cycle later. When no bus or function matches, a read gets all ones of the requested length and a write is dropped.

Functions are numbered flat: index = slot × `FUNCS_PER_BUS` + devfn. Slot 0 is the root bus and slot k+1 is the secondary bus of bridge k. Bridge k sits at root devfn `BRIDGE_DEVFN0` + k. Its presence bit and its select line are those of that root function.

Top module: `cfg_access_router`

## Requirements
- R1: The request address is split as follows: bits 23:16 give the bus, bits 15:8 give the devfn and bits 7:0 give the offset. `fnOffset`, `fnLen`, `fnWrite` and `fnWrData` carry the offset, length, write flag and data of the current request.
- R2: A request to bus 0 with devfn below `FUNCS_PER_BUS`, whose function is present, asserts the select of flat index devfn in the same cycle.
- R3: A request to a non-zero bus number equal to bridge k's secondary number goes to slot k+1. If several bridges hold the same number, the lowest k wins.
- R4: Secondary numbers reset to 0. A bridge whose number is 0 never claims a request.
- R5: A write of any length at offset 0x19 to a present bridge function loads that bridge's secondary number from data bits 7:0.
- R6: A write of length 2 or 4 at offset 0x18 to a present bridge loads the number from data bits 15:8. A length-1 write at offset 0x18 leaves the number unchanged.
- R7: A read that finds no matching bus, a devfn at or above `FUNCS_PER_BUS`, or an absent function asserts no select. It returns 0xFF for length 1, 0xFFFF for length 2, and 0xFFFFFFFF for length 4. Any other length code is treated as 4.
- R8: A write to a missing target asserts no select and changes no secondary number.
- R9: `rspValid` is high in exactly the cycle after each request cycle. On a read hit, `rspData` is the function's data masked to the length. A write returns 0.
- R10: At most one select is high at a time, and only while `reqValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Bus, devfn and offset |
| reqLen | input | 3 | Byte count: 1, 2 or 4 |
| reqWrData | input | 32 | Write data |
| presentMask | input | NUM_FN | One bit per flat function index, 1 = present |
| fnSel | output | NUM_FN | One-hot function select |
| fnWrite | output | 1 | Write flag to functions |
| fnOffset | output | 8 | Register offset to functions |
| fnLen | output | 3 | Length to functions |
| fnWrData | output | 32 | Write data to functions |
| fnRdData | input | NUM_FN*32 | Read data, 32 bits per function |
| rspValid | output | 1 | Response valid |
| rspData | output | 32 | Response data |

## Verification
The hardest case to reach is two bridges holding the same secondary number. A request to that number must then fall to the lower bridge. Once that bridge is cleared to 0, the same request must move to the other bridge. The stimulus produces this case only through configuration writes. It first programs the second bridge with a dword write at offset 0x18 so that its number duplicates the first bridge's. It then reissues the same bus request, clears the first bridge with a dword write at offset 0x19, and issues the request again.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef struct packed {
    logic       hit;        // a present function matches
    logic [15:0] fnIdx;     // flat function index of the match
    logic       capLo;      // load secondary number from data[7:0]
    logic       capHi;      // load secondary number from data[15:8]
    logic [7:0] capBridge;  // bridge whose number is loaded
  } cfgr_strb_t;

  function automatic logic [31:0] lenMask(input logic [2:0] len);
    case (len)
      3'd1:    lenMask = 32'h0000_00FF;
      3'd2:    lenMask = 32'h0000_FFFF;
      default: lenMask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
  import cfgr_pkg::*;
#(
  parameter int NUM_BRIDGES   = 2,
  parameter int FUNCS_PER_BUS = 4,
  parameter int BRIDGE_DEVFN0 = 2,
  localparam int NUM_FN       = (NUM_BRIDGES + 1) * FUNCS_PER_BUS
) (
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [23:0]              reqAddr,
  input  logic [2:0]               reqLen,
  input  logic [NUM_FN-1:0]        presentMask,
  input  logic [NUM_BRIDGES*8-1:0] secBusFlat,
  output cfgr_strb_t               strb
);

  logic [7:0] busNum, devfn, offs;
  logic       busFound;
  int         slot;
  int         flatIdx;
  logic       present;

  assign busNum = reqAddr[23:16];
  assign devfn  = reqAddr[15:8];
  assign offs   = reqAddr[7:0];

  // bus lookup: root first, then lowest-numbered bridge wins
  always_comb begin
    busFound = 1'b0;
    slot     = 0;
    if (busNum == 8'd0) begin
      busFound = 1'b1;
    end else begin
      for (int k = NUM_BRIDGES - 1; k >= 0; k--) begin
        if (secBusFlat[k*8 +: 8] == busNum) begin
          busFound = 1'b1;
          slot     = k + 1;
        end
      end
    end
  end

  always_comb begin
    flatIdx = slot * FUNCS_PER_BUS + int'(devfn);
    present = 1'b0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (flatIdx == i && presentMask[i]) present = 1'b1;
    end
    if (int'(devfn) >= FUNCS_PER_BUS) present = 1'b0;
  end

  always_comb begin
    strb           = '0;
    strb.hit       = reqValid && busFound && present;
    strb.fnIdx     = 16'(flatIdx);
    for (int k = 0; k < NUM_BRIDGES; k++) begin
      if (strb.hit && reqWrite && slot == 0 &&
          int'(devfn) == BRIDGE_DEVFN0 + k) begin
        strb.capBridge = 8'(k);
        if (offs == 8'h19)                       strb.capLo = 1'b1;
        else if (offs == 8'h18 && reqLen != 3'd1) strb.capHi = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgr_dp.sv
module cfgr_dp
  import cfgr_pkg::*;
#(
  parameter int NUM_BRIDGES   = 2,
  parameter int FUNCS_PER_BUS = 4,
  localparam int NUM_FN       = (NUM_BRIDGES + 1) * FUNCS_PER_BUS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgr_strb_t               strb,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [2:0]               reqLen,
  input  logic [31:0]              reqWrData,
  input  logic [NUM_FN*32-1:0]     fnRdData,
  output logic [NUM_FN-1:0]        fnSel,
  output logic [NUM_BRIDGES*8-1:0] secBusFlat,
  output logic                     rspValid,
  output logic [31:0]              rspData
);

  logic [31:0] hitData;

  for (genvar i = 0; i < NUM_FN; i++) begin : g_sel
    assign fnSel[i] = strb.hit && (strb.fnIdx == 16'(i));
  end

  for (genvar k = 0; k < NUM_BRIDGES; k++) begin : g_sec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        secBusFlat[k*8 +: 8] <= 8'd0;
      end else if (strb.capBridge == 8'(k)) begin
        if (strb.capLo)      secBusFlat[k*8 +: 8] <= reqWrData[7:0];
        else if (strb.capHi) secBusFlat[k*8 +: 8] <= reqWrData[15:8];
      end
    end
  end

  always_comb begin
    hitData = 32'd0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (fnSel[i]) hitData = fnRdData[i*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= 32'd0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        if (reqWrite)      rspData <= 32'd0;
        else if (strb.hit) rspData <= hitData & lenMask(reqLen);
        else               rspData <= lenMask(reqLen);
      end
    end
  end

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int NUM_BRIDGES   = 2,
  parameter int FUNCS_PER_BUS = 4,
  parameter int BRIDGE_DEVFN0 = 2,
  localparam int NUM_FN       = (NUM_BRIDGES + 1) * FUNCS_PER_BUS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [23:0]          reqAddr,
  input  logic [2:0]           reqLen,
  input  logic [31:0]          reqWrData,
  input  logic [NUM_FN-1:0]    presentMask,
  output logic [NUM_FN-1:0]    fnSel,
  output logic                 fnWrite,
  output logic [7:0]           fnOffset,
  output logic [2:0]           fnLen,
  output logic [31:0]          fnWrData,
  input  logic [NUM_FN*32-1:0] fnRdData,
  output logic                 rspValid,
  output logic [31:0]          rspData
);

  cfgr_strb_t               strb;
  logic [NUM_BRIDGES*8-1:0] secBusFlat;

  assign fnWrite  = reqWrite;
  assign fnOffset = reqAddr[7:0];
  assign fnLen    = reqLen;
  assign fnWrData = reqWrData;

  cfgr_ctrl #(
    .NUM_BRIDGES  (NUM_BRIDGES),
    .FUNCS_PER_BUS(FUNCS_PER_BUS),
    .BRIDGE_DEVFN0(BRIDGE_DEVFN0)
  ) u_ctrl (
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .presentMask(presentMask),
    .secBusFlat (secBusFlat),
    .strb       (strb)
  );

  cfgr_dp #(
    .NUM_BRIDGES  (NUM_BRIDGES),
    .FUNCS_PER_BUS(FUNCS_PER_BUS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqLen    (reqLen),
    .reqWrData (reqWrData),
    .fnRdData  (fnRdData),
    .fnSel     (fnSel),
    .secBusFlat(secBusFlat),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
  parameter int NUM_FN = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [2:0]        reqLen,
  input logic [NUM_FN-1:0] presentMask,
  input logic [NUM_FN-1:0] fnSel,
  input logic              rspValid,
  input logic [31:0]       rspData
);

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fnSel));

  p_sel_needs_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> fnSel == '0);

  p_sel_present_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fnSel & ~presentMask) == '0);

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> rspData == 32'd0);

  p_miss_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && fnSel == '0 && reqLen == 3'd1) |=> rspData == 32'h0000_00FF);

  p_miss_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && fnSel == '0 && reqLen == 3'd2) |=> rspData == 32'h0000_FFFF);

endmodule

bind cfg_access_router cfgr_checker #(.NUM_FN(NUM_FN)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqLen     (reqLen),
  .presentMask(presentMask),
  .fnSel      (fnSel),
  .rspValid   (rspValid),
  .rspData    (rspData)
);

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;

  localparam int NB = 2;
  localparam int FP = 4;
  localparam int BD0 = 2;
  localparam int NF = (NB + 1) * FP;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [23:0]       reqAddr = '0;
  logic [2:0]        reqLen = 3'd4;
  logic [31:0]       reqWrData = '0;
  logic [NF-1:0]     presentMask;
  logic [NF-1:0]     fnSel;
  logic              fnWrite;
  logic [7:0]        fnOffset;
  logic [2:0]        fnLen;
  logic [31:0]       fnWrData;
  logic [NF*32-1:0]  fnRdData;
  logic              rspValid;
  logic [31:0]       rspData;

  int checks = 0;
  int failures = 0;
  int secModel[NB];
  logic done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_access_router #(.NUM_BRIDGES(NB), .FUNCS_PER_BUS(FP), .BRIDGE_DEVFN0(BD0)) i_cfg_access_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrData(reqWrData), .presentMask(presentMask), .fnSel(fnSel),
    .fnWrite(fnWrite), .fnOffset(fnOffset), .fnLen(fnLen), .fnWrData(fnWrData),
    .fnRdData(fnRdData), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [31:0] fnValue(int i);
    return 32'hC0DE_0000 | (32'(i) << 8) | 32'(i * 3 + 1);
  endfunction

  function automatic logic [31:0] maskOf(logic [2:0] l);
    if (l == 3'd1) return 32'hFF;
    if (l == 3'd2) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(logic ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one request cycle; starts and ends on a falling edge
  task automatic cyc(logic v, logic w, logic [23:0] a, logic [2:0] l, logic [31:0] d, string tag);
    int slot;
    int idx;
    logic hit;
    logic [NF-1:0] expSel;
    logic [31:0] expRsp;
    int busN;
    int dv;
    int off;
    reqValid = v; reqWrite = w; reqAddr = a; reqLen = l; reqWrData = d;
    #1;
    busN = int'(a[23:16]); dv = int'(a[15:8]); off = int'(a[7:0]);
    slot = -1;
    if (busN == 0) slot = 0;
    else for (int k = 0; k < NB; k++) if (slot < 0 && secModel[k] == busN) slot = k + 1;
    idx = slot * FP + dv;
    hit = v && slot >= 0 && dv < FP && presentMask[idx];
    expSel = '0;
    if (hit) expSel[idx] = 1'b1;
    check(fnSel == expSel, tag, "select", 64'(fnSel), 64'(expSel));
    if (v) check(fnOffset == a[7:0] && fnLen == l && fnWrData == d && fnWrite == w,
                 "R1", "forwarded fields", {32'(fnOffset), fnWrData}, {32'(a[7:0]), d});
    if (w) expRsp = 32'd0;
    else if (hit) expRsp = fnValue(idx) & maskOf(l);
    else expRsp = maskOf(l);
    if (hit && w && slot == 0 && dv >= BD0 && dv < BD0 + NB) begin
      if (off == 8'h19) secModel[dv - BD0] = int'(d[7:0]);
      else if (off == 8'h18 && l != 3'd1) secModel[dv - BD0] = int'(d[15:8]);
    end
    @(negedge clk);
    check(rspValid == v, "R9", "rspValid", 64'(rspValid), 64'(v));
    if (v) check(rspData == expRsp, tag, "rspData", 64'(rspData), 64'(expRsp));
  endtask

  initial begin
    for (int i = 0; i < NF; i++) fnRdData[i*32 +: 32] = fnValue(i);
    presentMask = '1;
    presentMask[5] = 1'b0;  // bus slot 1, devfn 1 absent
    for (int k = 0; k < NB; k++) secModel[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0 && fnSel == '0, "R4", "reset state", 64'(rspValid), 64'd0);
    // root bus hits
    cyc(1, 0, 24'h00_00_10, 3'd4, 0, "R2");
    cyc(1, 0, 24'h00_01_04, 3'd1, 0, "R2");
    cyc(1, 0, 24'h00_03_08, 3'd2, 0, "R2");
    // unprogrammed bridges: bus 5 misses
    cyc(1, 0, 24'h05_00_00, 3'd4, 0, "R4");
    cyc(1, 0, 24'h05_00_00, 3'd2, 0, "R7");
    cyc(1, 0, 24'h05_00_00, 3'd1, 0, "R7");
    // program bridge 0 to bus 5 via 0x19 byte write
    cyc(1, 1, 24'h00_02_19, 3'd1, 32'h0000_0005, "R5");
    cyc(1, 0, 24'h05_00_0C, 3'd4, 0, "R3");
    cyc(1, 0, 24'h05_01_00, 3'd2, 0, "R7");
    // program bridge 1 to bus 7 via 0x18 word write
    cyc(1, 1, 24'h00_03_18, 3'd2, 32'h0000_0700, "R6");
    cyc(1, 0, 24'h07_02_00, 3'd4, 0, "R6");
    // byte write at 0x18 leaves number
    cyc(1, 1, 24'h00_03_18, 3'd1, 32'h0000_0900, "R6");
    cyc(1, 0, 24'h07_02_00, 3'd1, 0, "R6");
    cyc(1, 0, 24'h09_02_00, 3'd4, 0, "R6");
    // duplicate: bridge 1 also bus 5, lowest bridge wins
    cyc(1, 1, 24'h00_03_18, 3'd4, 32'h0005_0500, "R6");
    cyc(1, 0, 24'h05_03_00, 3'd4, 0, "R3");
    cyc(1, 0, 24'h07_02_00, 3'd4, 0, "R7");
    // writes to missing targets
    cyc(1, 1, 24'h20_00_19, 3'd1, 32'h0000_0033, "R8");
    cyc(1, 1, 24'h05_01_19, 3'd1, 32'h0000_0044, "R8");
    cyc(1, 0, 24'h05_03_00, 3'd4, 0, "R8");
    // odd length treated as 4, devfn out of range
    cyc(1, 0, 24'h00_00_00, 3'd3, 0, "R7");
    cyc(1, 0, 24'h00_40_00, 3'd3, 0, "R7");
    cyc(1, 0, 24'h00_40_00, 3'd1, 0, "R7");
    // idle cycles
    cyc(0, 0, 24'h00_00_00, 3'd4, 0, "R10");
    cyc(0, 1, 24'h00_02_19, 3'd1, 32'h0000_0011, "R10");
    cyc(1, 0, 24'h05_00_00, 3'd4, 0, "R8");
    // clear bridge 0 with dword at 0x19: bus 5 moves to bridge 1
    cyc(1, 1, 24'h00_02_19, 3'd4, 32'h1234_5600, "R5");
    cyc(1, 0, 24'h05_00_00, 3'd4, 0, "R3");
    cyc(1, 0, 24'h00_02_00, 3'd2, 0, "R2");
    cyc(0, 0, 24'h00_00_00, 3'd4, 0, "R9");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule